// File: doc/BRIEF.md
# Interrupt Stack Save/Restore Sequencer

This block moves processor state between a register snapshot and a descending byte-wide stack in memory. When an interrupt is taken, it receives the source kind (fast or full) and the current register values. It then issues one memory write per byte of the frame, with the stack pointer pre-decremented. After the frame it issues two reads of the vector address, which load the new program counter. When an interrupt returns, it issues post-incrementing reads. It always pulls the condition-code byte first and uses that byte to decide how long the rest of the frame is.

A full frame holds twelve bytes: CC, A, B, DP, X, Y, U and PC. A fast frame holds only CC and PC. The frame kind is recorded in bit 7 of the stacked condition code (the entire-state flag). Each bus cycle lasts one clock, and read data is taken during the same cycle. The block does not execute instructions and does not arbitrate vectors.

Top module: `isr_stack_seq`

## Requirements
- R1: A fast entry (`fast_i`=1) writes three bytes at `sp_i`-1, `sp_i`-2 and `sp_i`-3, in that order: PC[7:0], PC[15:8], and CC with bit 7 cleared.
- R2: A full entry writes twelve bytes at `sp_i`-1 down to `sp_i`-12, in this order: PC lo, PC hi, U lo, U hi, Y lo, Y hi, X lo, X hi, DP, B, A, and CC with bit 7 set.
- R3: The stack pointer is decremented before every push write. After entry, `sp_o` equals `sp_i` minus the frame length.
- R4: After the last push write, the block reads `vec_addr_i` and then `vec_addr_i`+1. `pc_o` becomes {first byte, second byte}, and `cc_o` holds the stacked CC.
- R5: A return reads CC at `sp_i` first. If bit 7 of that byte is 1, eleven more bytes follow (A, B, DP, X hi, X lo, Y hi, Y lo, U hi, U lo, PC hi, PC lo). If it is 0, only PC hi and PC lo follow. The stack pointer increments after each read, so `sp_o` ends one past the last byte read.
- R6: After a return, `cc_o` equals the pulled CC byte, which restores the masks in force before the interrupt. `pc_o` equals the pulled PC. After a full frame, U, Y, X, DP, B and A are also restored.
- R7: `busy_o` is high from the cycle after an accepted strobe through the final bus cycle. Strobes that arrive while busy are ignored.
- R8: `done_o` is a one-cycle pulse in the cycle after the final bus cycle. `bus_valid_o` is low whenever the block is not busy. After reset all outputs are zero.
- R9: If `entry_i` and `ret_i` are both high in an idle cycle, the entry is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| entry_i | input | 1 | Start interrupt entry |
| ret_i | input | 1 | Start return from interrupt |
| fast_i | input | 1 | Entry source is the fast interrupt (short frame) |
| vec_addr_i | input | AW | Address of the vector high byte |
| sp_i | input | AW | Stack pointer at command start |
| pc_i | input | 16 | Program counter snapshot |
| u_i | input | 16 | U snapshot |
| y_i | input | 16 | Y snapshot |
| x_i | input | 16 | X snapshot |
| dp_i | input | 8 | DP snapshot |
| b_i | input | 8 | B snapshot |
| a_i | input | 8 | A snapshot |
| cc_i | input | 8 | CC snapshot |
| bus_valid_o | output | 1 | Bus cycle active |
| bus_we_o | output | 1 | Bus cycle is a write |
| bus_addr_o | output | AW | Bus address |
| bus_wdata_o | output | 8 | Write data |
| bus_rdata_i | input | 8 | Read data, valid in the same cycle |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished (one cycle) |
| sp_o | output | AW | Current stack pointer |
| pc_o | output | 16 | Program counter result |
| u_o | output | 16 | U result |
| y_o | output | 16 | Y result |
| x_o | output | 16 | X result |
| dp_o | output | 8 | DP result |
| b_o | output | 8 | B result |
| a_o | output | 8 | A result |
| cc_o | output | 8 | CC result |

## Verification
Several properties are checked on every cycle. The stacked CC carries the correct frame flag for the frame kind. The stack pointer moves by exactly one on each push write and each pull read. `done_o` lasts one cycle and comes only at the end of a busy period. Frame byte order, the addresses used, the loaded vector, the restored registers, the frame-length decision taken from the pulled CC, and nesting a full frame inside a fast one can only be shown by the bench scenarios, which compare memory contents and outputs against values computed from the snapshots.

// File: rtl/isr_seq_pkg.sv
package isr_seq_pkg;
  localparam int FRAME_N = 12;
  localparam int SHORT_N = 3;

  typedef logic [3:0] idx_t;

  // frame byte index == push order position for a full frame
  localparam idx_t IX_PCL = 4'd0;
  localparam idx_t IX_PCH = 4'd1;
  localparam idx_t IX_UL  = 4'd2;
  localparam idx_t IX_UH  = 4'd3;
  localparam idx_t IX_YL  = 4'd4;
  localparam idx_t IX_YH  = 4'd5;
  localparam idx_t IX_XL  = 4'd6;
  localparam idx_t IX_XH  = 4'd7;
  localparam idx_t IX_DP  = 4'd8;
  localparam idx_t IX_B   = 4'd9;
  localparam idx_t IX_A   = 4'd10;
  localparam idx_t IX_CC  = 4'd11;

  localparam idx_t LAST_FULL  = idx_t'(FRAME_N - 1);
  localparam idx_t LAST_SHORT = idx_t'(SHORT_N - 1);

  typedef enum logic [2:0] {ST_IDLE, ST_PUSH, ST_VHI, ST_VLO, ST_PULL} st_e;

  function automatic idx_t push_idx(input logic short_f, input idx_t n);
    if (!short_f) return n;
    case (n)
      4'd0:    return IX_PCL;
      4'd1:    return IX_PCH;
      default: return IX_CC;
    endcase
  endfunction

  function automatic idx_t pull_idx(input logic short_f, input idx_t n);
    if (n == 4'd0) return IX_CC;
    if (short_f) return (n == 4'd1) ? IX_PCH : IX_PCL;
    return idx_t'(LAST_FULL - n);
  endfunction
endpackage

// File: rtl/isr_sp_unit.sv
module isr_sp_unit #(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          dec_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] sp_o
);
  logic [AW-1:0] sp_q;
  logic [AW-1:0] sp_dec;

  assign sp_dec = sp_q - AW'(1);
  assign addr_o = dec_i ? sp_dec : sp_q;  // pre-decrement on push, post-increment on pull
  assign sp_o   = sp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sp_q <= '0;
    else if (load_i) sp_q <= load_val_i;
    else if (dec_i)  sp_q <= sp_dec;
    else if (inc_i)  sp_q <= sp_q + AW'(1);
  end

  AST_PUSH_ADDR_BELOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |=> (sp_o == $past(addr_o))) else $error("push step"); // R3
endmodule

// File: rtl/isr_frame_regs.sv
module isr_frame_regs
  import isr_seq_pkg::*;
#(
  parameter int N = FRAME_N
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [N-1:0][7:0] snap_i,
  input  logic              wr_en_i,
  input  idx_t              wr_idx_i,
  input  logic [7:0]        wr_data_i,
  output logic [N-1:0][7:0] q_o
);
  for (genvar g = 0; g < N; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               q_o[g] <= '0;
      else if (load_i)                           q_o[g] <= snap_i[g];
      else if (wr_en_i && wr_idx_i == idx_t'(g)) q_o[g] <= wr_data_i;
    end
  end
endmodule

// File: rtl/isr_stack_seq.sv
module isr_stack_seq
  import isr_seq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int E_BIT = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          entry_i,
  input  logic          ret_i,
  input  logic          fast_i,
  input  logic [AW-1:0] vec_addr_i,
  input  logic [AW-1:0] sp_i,
  input  logic [15:0]   pc_i,
  input  logic [15:0]   u_i,
  input  logic [15:0]   y_i,
  input  logic [15:0]   x_i,
  input  logic [7:0]    dp_i,
  input  logic [7:0]    b_i,
  input  logic [7:0]    a_i,
  input  logic [7:0]    cc_i,
  output logic          bus_valid_o,
  output logic          bus_we_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [7:0]    bus_wdata_o,
  input  logic [7:0]    bus_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] sp_o,
  output logic [15:0]   pc_o,
  output logic [15:0]   u_o,
  output logic [15:0]   y_o,
  output logic [15:0]   x_o,
  output logic [7:0]    dp_o,
  output logic [7:0]    b_o,
  output logic [7:0]    a_o,
  output logic [7:0]    cc_o
);
  st_e           st_q, st_d;
  idx_t          cnt_q;
  logic          short_q;
  logic [AW-1:0] vec_q;
  logic          done_q;

  logic          start, start_entry, start_ret;
  logic          last_step;
  idx_t          cur_idx;
  logic [AW-1:0] sp_addr;

  logic [FRAME_N-1:0][7:0] snap, frame;
  logic [7:0]    cc_stk;
  logic          fr_wr;
  idx_t          fr_idx;

  assign start       = (st_q == ST_IDLE) && (entry_i || ret_i);
  assign start_entry = start && entry_i;           // entry wins a tie
  assign start_ret   = start && !entry_i;
  assign last_step   = (cnt_q != 4'd0) && (cnt_q == (short_q ? LAST_SHORT : LAST_FULL));
  assign cur_idx     = (st_q == ST_PULL) ? pull_idx(short_q, cnt_q) : push_idx(short_q, cnt_q);

  // entire-state flag written into the stacked CC
  always_comb begin
    cc_stk        = cc_i;
    cc_stk[E_BIT] = !fast_i;
  end

  always_comb begin
    snap         = '0;
    snap[IX_PCL] = pc_i[7:0];
    snap[IX_PCH] = pc_i[15:8];
    snap[IX_UL]  = u_i[7:0];
    snap[IX_UH]  = u_i[15:8];
    snap[IX_YL]  = y_i[7:0];
    snap[IX_YH]  = y_i[15:8];
    snap[IX_XL]  = x_i[7:0];
    snap[IX_XH]  = x_i[15:8];
    snap[IX_DP]  = dp_i;
    snap[IX_B]   = b_i;
    snap[IX_A]   = a_i;
    snap[IX_CC]  = cc_stk;
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (start_entry) st_d = ST_PUSH;
               else if (start_ret) st_d = ST_PULL;
      ST_PUSH: if (cnt_q == (short_q ? LAST_SHORT : LAST_FULL)) st_d = ST_VHI;
      ST_VHI:  st_d = ST_VLO;
      ST_VLO:  st_d = ST_IDLE;
      ST_PULL: if (last_step) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      short_q <= 1'b0;
      vec_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ST_VLO) || (st_q == ST_PULL && last_step);
      if (start) begin
        cnt_q   <= '0;
        short_q <= start_entry && fast_i;
        vec_q   <= vec_addr_i;
      end else if (st_q == ST_PUSH || st_q == ST_PULL) begin
        cnt_q <= (st_d == st_q) ? cnt_q + 4'd1 : '0;
        if (st_q == ST_PULL && cnt_q == 4'd0) short_q <= !bus_rdata_i[E_BIT];
      end
    end
  end

  isr_sp_unit #(.AW(AW)) i_sp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (start),
    .load_val_i (sp_i),
    .dec_i      (st_q == ST_PUSH),
    .inc_i      (st_q == ST_PULL),
    .addr_o     (sp_addr),
    .sp_o       (sp_o)
  );

  always_comb begin
    fr_wr  = 1'b0;
    fr_idx = cur_idx;
    case (st_q)
      ST_PULL: fr_wr = 1'b1;
      ST_VHI:  begin fr_wr = 1'b1; fr_idx = IX_PCH; end
      ST_VLO:  begin fr_wr = 1'b1; fr_idx = IX_PCL; end
      default: ;
    endcase
  end

  isr_frame_regs #(.N(FRAME_N)) i_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (start_entry),
    .snap_i    (snap),
    .wr_en_i   (fr_wr),
    .wr_idx_i  (fr_idx),
    .wr_data_i (bus_rdata_i),
    .q_o       (frame)
  );

  assign bus_valid_o = (st_q != ST_IDLE);
  assign bus_we_o    = (st_q == ST_PUSH);
  assign bus_wdata_o = bus_we_o ? frame[cur_idx] : '0;
  always_comb begin
    case (st_q)
      ST_VHI:  bus_addr_o = vec_q;
      ST_VLO:  bus_addr_o = vec_q + AW'(1);
      ST_IDLE: bus_addr_o = '0;
      default: bus_addr_o = sp_addr;
    endcase
  end

  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign pc_o   = {frame[IX_PCH], frame[IX_PCL]};
  assign u_o    = {frame[IX_UH], frame[IX_UL]};
  assign y_o    = {frame[IX_YH], frame[IX_YL]};
  assign x_o    = {frame[IX_XH], frame[IX_XL]};
  assign dp_o   = frame[IX_DP];
  assign b_o    = frame[IX_B];
  assign a_o    = frame[IX_A];
  assign cc_o   = frame[IX_CC];

  AST_FAST_E_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o && cur_idx == IX_CC && short_q) |-> !bus_wdata_o[E_BIT]) else $error("E set"); // R1
  AST_FULL_E_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_we_o && cur_idx == IX_CC && !short_q) |-> bus_wdata_o[E_BIT]) else $error("E clr"); // R2
  AST_PULL_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PULL) |=> (sp_o == $past(sp_o) + AW'(1))) else $error("pull step"); // R5
  AST_DONE_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done width"); // R8
  AST_DONE_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o))) else $error("done timing"); // R7
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !$past(done_o) && $past(busy_o) && cnt_q != 4'd0) |-> $stable(vec_q)) else $error("restart"); // R7
endmodule

// File: tb/test_isr_stack_seq.sv
module test_isr_stack_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;

  typedef struct packed {
    logic        fast;
    logic [15:0] pc, u, y, x;
    logic [7:0]  dp, b, a, cc;
    logic [15:0] sp, vec;
  } row_t;

  localparam row_t ROWS [4] = '{
    '{1'b0, 16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 8'h11, 8'h22, 8'h33, 8'h45, 16'h0080, 16'h00F6},
    '{1'b1, 16'hA1B2, 16'h0001, 16'h0002, 16'h0003, 8'h44, 8'h55, 8'h66, 8'hD5, 16'h0060, 16'h00F8},
    '{1'b0, 16'hFFEE, 16'hC3C3, 16'h3C3C, 16'h0F0F, 8'h99, 8'hAA, 8'hBB, 8'h00, 16'h00C0, 16'h00F6},
    '{1'b1, 16'h0102, 16'h7777, 16'h8888, 16'h9999, 8'hEE, 8'hDD, 8'hCC, 8'h10, 16'h0040, 16'h00F8}
  };

  logic clk = 0, rst_ni = 0;
  logic entry_i = 0, ret_i = 0, fast_i = 0;
  logic [AW-1:0] vec_addr_i = '0, sp_i = '0;
  logic [15:0] pc_i = '0, u_i = '0, y_i = '0, x_i = '0;
  logic [7:0] dp_i = '0, b_i = '0, a_i = '0, cc_i = '0;
  logic bus_valid_o, bus_we_o, busy_o, done_o;
  logic [AW-1:0] bus_addr_o, sp_o;
  logic [7:0] bus_wdata_o, bus_rdata_i;
  logic [15:0] pc_o, u_o, y_o, x_o;
  logic [7:0] dp_o, b_o, a_o, cc_o;

  logic [7:0] mem [256];
  int checks = 0, errors = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign bus_rdata_i = mem[bus_addr_o[7:0]];
  always @(posedge clk) if (bus_valid_o && bus_we_o) mem[bus_addr_o[7:0]] <= bus_wdata_o;

  isr_stack_seq #(.AW(AW)) i_isr_stack_seq (
    .clk_i(clk), .rst_ni(rst_ni), .entry_i(entry_i), .ret_i(ret_i), .fast_i(fast_i),
    .vec_addr_i(vec_addr_i), .sp_i(sp_i), .pc_i(pc_i), .u_i(u_i), .y_i(y_i), .x_i(x_i),
    .dp_i(dp_i), .b_i(b_i), .a_i(a_i), .cc_i(cc_i),
    .bus_valid_o(bus_valid_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_rdata_i(bus_rdata_i), .busy_o(busy_o), .done_o(done_o),
    .sp_o(sp_o), .pc_o(pc_o), .u_o(u_o), .y_o(y_o), .x_o(x_o), .dp_o(dp_o), .b_o(b_o),
    .a_o(a_o), .cc_o(cc_o));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog: run did not complete, act %0d exp <100000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act %h exp %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] stk_cc(input row_t r);
    return r.fast ? (r.cc & 8'h7F) : (r.cc | 8'h80);
  endfunction

  function automatic logic [7:0] push_byte(input row_t r, input int k);
    case (k)
      0: return r.pc[7:0];   1: return r.pc[15:8];
      2: return r.u[7:0];    3: return r.u[15:8];
      4: return r.y[7:0];    5: return r.y[15:8];
      6: return r.x[7:0];    7: return r.x[15:8];
      8: return r.dp;        9: return r.b;
      10: return r.a;        default: return stk_cc(r);
    endcase
  endfunction

  // count bus cycles until done; flags any cycle with bus active but not busy
  task automatic wait_done(output int n);
    n = 0;
    for (int g = 0; g < 100; g++) begin
      if (done_o) break;
      if (bus_valid_o) begin
        n++;
        if (!busy_o) chk("R7 busy during bus cycle", 0, 1);
      end
      @(negedge clk);
    end
    chk("R8 busy low at done", {31'd0, busy_o}, 0);
    @(negedge clk);
    chk("R8 done one cycle", {31'd0, done_o}, 0);
  endtask

  task automatic drive_row(input row_t r);
    fast_i = r.fast; vec_addr_i = r.vec; sp_i = r.sp;
    pc_i = r.pc; u_i = r.u; y_i = r.y; x_i = r.x;
    dp_i = r.dp; b_i = r.b; a_i = r.a; cc_i = r.cc;
  endtask

  task automatic scramble;
    pc_i = 16'hDEAD; u_i = 16'hBEEF; y_i = 16'h0BAD; x_i = 16'hF00D;
    dp_i = 8'h5A; b_i = 8'hA5; a_i = 8'h3C; cc_i = 8'hFF; fast_i = 1'b1;
  endtask

  task automatic do_entry(input row_t r, output int n);
    drive_row(r);
    entry_i = 1;
    @(negedge clk);
    entry_i = 0;
    wait_done(n);
  endtask

  task automatic do_ret(input logic [AW-1:0] sp, output int n);
    scramble();
    sp_i = sp;
    ret_i = 1;
    @(negedge clk);
    ret_i = 0;
    wait_done(n);
  endtask

  task automatic check_entry(input row_t r, input int n);
    int len;
    len = r.fast ? 3 : 12;
    if (r.fast) begin
      chk("R1 fast bus cycles", n, 5);
      chk("R1 fast PC lo", {24'd0, mem[8'(r.sp - 1)]}, {24'd0, r.pc[7:0]});
      chk("R1 fast PC hi", {24'd0, mem[8'(r.sp - 2)]}, {24'd0, r.pc[15:8]});
      chk("R1 fast CC E clear", {24'd0, mem[8'(r.sp - 3)]}, {24'd0, stk_cc(r)});
    end else begin
      chk("R2 full bus cycles", n, 14);
      for (int k = 0; k < 12; k++)
        chk("R2 full frame byte", {24'd0, mem[8'(r.sp - 1 - k)]}, {24'd0, push_byte(r, k)});
    end
    chk("R3 sp after entry", {16'd0, sp_o}, {16'd0, 16'(r.sp - len)});
    chk("R4 vector PC", {16'd0, pc_o}, {16'd0, mem[r.vec[7:0]], mem[8'(r.vec + 1)]});
    chk("R4 cc_o stacked", {24'd0, cc_o}, {24'd0, stk_cc(r)});
  endtask

  task automatic check_ret(input row_t r, input int n);
    chk("R5 return bus cycles", n, r.fast ? 3 : 12);
    chk("R5 sp after return", {16'd0, sp_o}, {16'd0, r.sp});
    chk("R6 cc restored", {24'd0, cc_o}, {24'd0, stk_cc(r)});
    chk("R6 pc restored", {16'd0, pc_o}, {16'd0, r.pc});
    if (!r.fast) begin
      chk("R6 u restored", {16'd0, u_o}, {16'd0, r.u});
      chk("R6 y restored", {16'd0, y_o}, {16'd0, r.y});
      chk("R6 x restored", {16'd0, x_o}, {16'd0, r.x});
      chk("R6 dp/b/a restored", {8'd0, dp_o, b_o, a_o}, {8'd0, r.dp, r.b, r.a});
    end
  endtask

  initial begin
    int n;
    row_t ra, rb;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h5C);
    mem[8'hF6] = 8'hC3; mem[8'hF7] = 8'h5A;
    mem[8'hF8] = 8'h7E; mem[8'hF9] = 8'h01;
    repeat (3) @(negedge clk);
    // R8: reset state
    chk("R8 reset busy", {31'd0, busy_o}, 0);
    chk("R8 reset done", {31'd0, done_o}, 0);
    chk("R8 reset bus", {31'd0, bus_valid_o}, 0);
    chk("R8 reset pc/sp", {pc_o, sp_o}, 0);
    rst_ni = 1;
    @(negedge clk);

    // table walk: entry then return for each row
    for (int i = 0; i < 4; i++) begin
      do_entry(ROWS[i], n);
      check_entry(ROWS[i], n);
      do_ret(ROWS[i].sp - (ROWS[i].fast ? 16'd3 : 16'd12), n);
      check_ret(ROWS[i], n);
    end

    // nested: full entry inside a fast service routine
    ra = ROWS[1]; ra.sp = 16'h0090;
    rb = ROWS[2]; rb.sp = 16'h008D;
    do_entry(ra, n);
    check_entry(ra, n);
    do_entry(rb, n);
    check_entry(rb, n);
    do_ret(16'h0081, n);
    check_ret(rb, n);
    do_ret(16'h008D, n);
    check_ret(ra, n);

    // R7: strobes while busy ignored
    drive_row(ROWS[0]);
    entry_i = 1;
    @(negedge clk);
    entry_i = 0;
    n = 0;
    for (int g = 0; g < 100; g++) begin
      if (done_o) break;
      if (bus_valid_o) n++;
      if (g == 3) begin entry_i = 1; ret_i = 1; fast_i = 1; sp_i = 16'h0020; end
      else begin entry_i = 0; ret_i = 0; end
      @(negedge clk);
    end
    entry_i = 0; ret_i = 0;
    chk("R7 strobes ignored, cycle count", n, 14);
    chk("R7 strobes ignored, sp", {16'd0, sp_o}, {16'd0, 16'(ROWS[0].sp - 12)});
    @(negedge clk);
    chk("R7 no restart", {31'd0, busy_o}, 0);

    // R9: entry wins when both strobes arrive together
    drive_row(ROWS[3]);
    entry_i = 1; ret_i = 1;
    @(negedge clk);
    entry_i = 0; ret_i = 0;
    chk("R9 first cycle is write", {31'd0, bus_we_o}, 1);
    wait_done(n);
    check_entry(ROWS[3], n);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule